// File: doc/BRIEF.md
# Nibble-Register Serial Bus Master

This block lets a host read or write one 4-bit register of a small peripheral over a three-wire link. The link has a chip enable, a serial clock and a bidirectional data line. The host raises `req` with an address, a direction and, for a write, a data nibble. The block takes the request in the cycle that `ack` is high. It shifts out one or two flag-tagged command bytes, clocks in the reply for a read, and pulses `done`. For a read, the received low nibble is valid on `rdata` when `done` is high.

Every serial bit lasts two half-periods of `HALF_CYC` system clocks each. The serial clock is high for the first half-period and low for the second. A transmitted bit is placed on the line when its high half-period starts. A received bit is sampled on the last system clock of its high half-period, just before the serial clock goes low. The client can hold chip enable high through `hold_en`, so that several accesses share one enable window. With `hold_en` low, chip enable drops after each access, and `done` comes only after a recovery half-period. `HALF_CYC` must be at least 2.

The controller has the states IDLE, TX_HI, TX_LO, RX_HI, RX_LO, TAIL, RECOV and DONE. Its transitions are:
- IDLE to TX_HI when a request is accepted.
- TX_HI to TX_LO, and TX_LO back to TX_HI for the next bit.
- TX_LO to TX_HI to start the data byte of a write.
- TX_LO to RX_HI after the command byte of a read.
- TX_LO to TAIL after the last bit of a write.
- RX_HI to RX_LO, and RX_LO to RX_HI for the next bit.
- RX_LO to TAIL after the eighth received bit.
- TAIL to DONE when `hold_en` is high, or TAIL to RECOV when it is low.
- RECOV to DONE.
- DONE to IDLE.

Top module: `nibreg_serial_master`

## Requirements
- R1: While `rst_n` is low and `hold_en` is low, `ser_ce` is 0, `ser_clk` is 1, `sd_oe` is 0, `busy` is 0 and `done` is 0.
- R2: `ack` is high only while the block is idle and `req` is high. `busy` goes high on the cycle after `ack` and stays high up to and including the `done` cycle. It is low on the cycle after `done`. A request raised while `busy` is high gets no `ack` and sends no bytes.
- R3: Each byte goes out MSB first over 8 serial clock pulses. Each low phase lasts exactly `HALF_CYC` system clocks, and `sd_o` does not change while `ser_clk` is low.
- R4: During a transmitted byte, `sd_oe` goes high on the second cycle of the first bit's high phase. It stays high until the end of the eighth bit's low phase. It is low during every received bit.
- R5: A read sends the single command byte `0x60 | addr`, with the read flag in bit 6 and the address flag in bit 5. It then clocks in 8 bits, MSB first, each sampled on the last cycle of its high phase.
- R6: After a read, `rdata` equals the low 4 bits of the received byte. The received upper 4 bits have no effect.
- R7: A write sends `0x20 | addr` and then `0x10 | wdata`, with the data flag in bit 4.
- R8: `ser_ce` is high whenever `ser_clk` is low.
- R9: With `hold_en` high, `ser_ce` stays high across back-to-back accesses. With `hold_en` low, `ser_ce` stays low for at least `HALF_CYC` cycles between two accesses.
- R10: `done` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write nibble |
| hold_en | input | 1 | Keeps chip enable high between accesses |
| ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | 4 | Read nibble, valid with done |
| ser_ce | output | 1 | Serial chip enable |
| ser_clk | output | 1 | Serial clock, idles high |
| sd_o | output | 1 | Serial data out |
| sd_oe | output | 1 | Data-line output enable |
| sd_i | input | 1 | Serial data in |

## Verification
The embedded assertions check the following on every cycle:
- chip enable is high whenever the serial clock is low;
- the output enable rises only while the clock is high and is never on while a bit is being received;
- data holds steady through each low phase;
- the half-period counter and bit counter stay in range;
- `busy` follows `ack` and falls only after `done`.

Only the bench scenarios can show the rest. These are the exact byte values and the flag bits, the reassembly of the reply with its upper nibble dropped, and the exact width of each low phase. They also include whether chip enable is kept or released between accesses, and whether a request raised mid-access is ignored.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    localparam logic [BYTE_W-1:0] FLAG_RD = 8'h40;
    localparam logic [BYTE_W-1:0] FLAG_AD = 8'h20;
    localparam logic [BYTE_W-1:0] FLAG_DT = 8'h10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TX_HI,
        S_TX_LO,
        S_RX_HI,
        S_RX_LO,
        S_TAIL,
        S_RECOV,
        S_DONE
    } nsm_state_e;
endpackage

// File: rtl/nsm_halftick.sv
module nsm_halftick #(
    parameter int HALF_CYC = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic first,
    output logic last
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    assign first = (cnt == '0);
    assign last  = (cnt == CW'(HALF_CYC - 1));

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(HALF_CYC - 1)); // R3
endmodule

// File: rtl/nsm_byteshift.sv
module nsm_byteshift #(
    parameter int BYTE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [BYTE_W-1:0]          load_val,
    input  logic                       shift,
    input  logic                       sin,
    output logic [BYTE_W-1:0]          q,
    output logic                       msb,
    output logic [$clog2(BYTE_W+1)-1:0] bitn
);
    localparam int BCW = $clog2(BYTE_W + 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            bitn <= '0;
        end else if (load) begin
            q    <= load_val;
            bitn <= '0;
        end else if (shift) begin
            q    <= {q[BYTE_W-2:0], sin};
            bitn <= bitn + 1'b1;
        end
    end

    assign msb = q[BYTE_W-1];

    AST_BITN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        bitn <= BCW'(BYTE_W)); // R3
endmodule

// File: rtl/nibreg_serial_master.sv
module nibreg_serial_master
    import nsm_pkg::*;
#(
    parameter int HALF_CYC = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             rd_nwr,
    input  logic [NIB_W-1:0] addr,
    input  logic [NIB_W-1:0] wdata,
    input  logic             hold_en,
    output logic             ack,
    output logic             busy,
    output logic             done,
    output logic [NIB_W-1:0] rdata,
    output logic             ser_ce,
    output logic             ser_clk,
    output logic             sd_o,
    output logic             sd_oe,
    input  logic             sd_i
);
    localparam int BCW = $clog2(BYTE_W + 1);
    localparam logic [BCW-1:0] LAST_TX = BCW'(BYTE_W - 1);
    localparam logic [BCW-1:0] ALL_RX  = BCW'(BYTE_W);

    nsm_state_e st, nxt;

    logic              op_rd, second;
    logic [NIB_W-1:0]  wd_q;
    logic              t_first, t_last, t_clr;
    logic              ld, sh_en;
    logic [BYTE_W-1:0] ld_val, sr_q;
    logic              sr_msb;
    logic [BCW-1:0]    bitn;

    nsm_halftick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(t_clr), .first(t_first), .last(t_last)
    );

    nsm_byteshift #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
        .shift(sh_en), .sin(sd_i), .q(sr_q), .msb(sr_msb), .bitn(bitn)
    );

    // next-state and datapath control
    always_comb begin
        nxt    = st;
        ld     = 1'b0;
        ld_val = '0;
        sh_en  = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (req) begin
                    nxt    = S_TX_HI;
                    ld     = 1'b1;
                    ld_val = (rd_nwr ? (FLAG_RD | FLAG_AD) : FLAG_AD)
                             | {{(BYTE_W-NIB_W){1'b0}}, addr};
                end
            end
            S_TX_HI: if (t_last) nxt = S_TX_LO;
            S_TX_LO: begin
                if (t_last) begin
                    if (bitn != LAST_TX) begin
                        sh_en = 1'b1;
                        nxt   = S_TX_HI;
                    end else if (!op_rd && !second) begin
                        ld     = 1'b1;
                        ld_val = FLAG_DT | {{(BYTE_W-NIB_W){1'b0}}, wd_q};
                        nxt    = S_TX_HI;
                    end else if (!op_rd) begin
                        nxt = S_TAIL;
                    end else begin
                        ld  = 1'b1;
                        nxt = S_RX_HI;
                    end
                end
            end
            S_RX_HI: begin
                if (t_last) begin
                    sh_en = 1'b1;
                    nxt   = S_RX_LO;
                end
            end
            S_RX_LO: if (t_last) nxt = (bitn == ALL_RX) ? S_TAIL : S_RX_HI;
            S_TAIL:  if (t_last) nxt = hold_en ? S_DONE : S_RECOV;
            S_RECOV: if (t_last) nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
        endcase
    end

    assign t_clr = (nxt != st) || (st == S_IDLE) || (st == S_DONE);

    // state and captured registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            op_rd  <= 1'b0;
            second <= 1'b0;
            wd_q   <= '0;
            rdata  <= '0;
        end else begin
            st <= nxt;
            if (st == S_IDLE && req) begin
                op_rd  <= rd_nwr;
                wd_q   <= wdata;
                second <= 1'b0;
            end else if (st == S_TX_LO && ld && !op_rd) begin
                second <= 1'b1;
            end
            if (st == S_RX_LO && t_last && bitn == ALL_RX)
                rdata <= sr_q[NIB_W-1:0];
        end
    end

    // outputs
    always_comb begin
        ack     = (st == S_IDLE) && req;
        busy    = (st != S_IDLE);
        done    = (st == S_DONE);
        ser_clk = !((st == S_TX_LO) || (st == S_RX_LO));
        sd_oe   = ((st == S_TX_HI) && !(t_first && bitn == '0)) || (st == S_TX_LO);
        sd_o    = ((st == S_TX_HI) || (st == S_TX_LO)) ? sr_msb : 1'b0;
        ser_ce  = hold_en || (st inside {S_TX_HI, S_TX_LO, S_RX_HI, S_RX_LO, S_TAIL});
    end

    AST_BUSY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> busy); // R2
    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done)); // R2
    AST_DATA_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_clk && !$past(ser_clk)) |-> $stable(sd_o)); // R3
    AST_OE_RISES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_oe) |-> ser_clk); // R4
    AST_NO_OE_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RX_HI || st == S_RX_LO) |-> !sd_oe); // R4
    AST_CE_WHILE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_clk |-> ser_ce); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
endmodule

// File: tb/nibreg_serial_master_tb.sv
module nibreg_serial_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0, rd_nwr = 1'b0, hold_en = 1'b0, sd_i = 1'b0;
    logic [3:0] addr = '0, wdata = '0;
    logic ack, busy, done, ser_ce, ser_clk, sd_o, sd_oe;
    logic [3:0] rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibreg_serial_master #(.HALF_CYC(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .rd_nwr(rd_nwr), .addr(addr),
        .wdata(wdata), .hold_en(hold_en), .ack(ack), .busy(busy), .done(done),
        .rdata(rdata), .ser_ce(ser_ce), .ser_clk(ser_clk), .sd_o(sd_o),
        .sd_oe(sd_oe), .sd_i(sd_i)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct { bit rd; logic [3:0] v; } done_t;
    logic [7:0] byte_q[$];
    done_t      done_q[$];
    logic [3:0] ref_mem [16];
    logic [3:0] dev_mem [16];

    // peripheral model and link monitors
    logic pclk = 1'b1, pce = 1'b0, rd_mode = 1'b0, rd_arm = 1'b0, wr_pend = 1'b0;
    logic [7:0] shb = '0, rbyte = '0;
    logic [3:0] wr_addr = '0;
    int nb = 0, rbit = 0, lowcnt = 0, ce_low_run = 0;
    int oe_err = 0, width_err = 0, ce_err = 0, gap_err = 0, ce_falls = 0;
    bit ce_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ser_clk) lowcnt++;
            if (pclk && !ser_clk) begin
                if (!ser_ce) ce_err++;
                if (rd_mode) begin
                    if (sd_oe) oe_err++;
                    rbit++;
                    if (rbit == 8) rd_mode = 1'b0;
                    else sd_i = rbyte[7-rbit];
                end else begin
                    if (!sd_oe) oe_err++;
                    shb = {shb[6:0], sd_o};
                    nb++;
                    if (nb == 8) begin
                        nb = 0;
                        if (byte_q.size() == 0) chk(0, "R5/R7 unexpected byte", shb, 0);
                        else chk(shb == byte_q[0], "R5/R7 command byte", shb, byte_q[0]);
                        if (byte_q.size() != 0) void'(byte_q.pop_front());
                        if (shb[6] && shb[5]) begin
                            rbyte  = {~shb[3:0], dev_mem[shb[3:0]]};
                            rd_arm = 1'b1;
                        end else if (shb[5]) begin
                            wr_addr = shb[3:0];
                            wr_pend = 1'b1;
                        end else if (shb[4] && wr_pend) begin
                            dev_mem[wr_addr] = shb[3:0];
                            wr_pend = 1'b0;
                        end
                    end
                end
            end
            if (!pclk && ser_clk) begin
                if (lowcnt != HALF) width_err++;
                lowcnt = 0;
                if (rd_arm) begin
                    rd_arm = 1'b0; rd_mode = 1'b1; rbit = 0; sd_i = rbyte[7];
                end
            end
            if (pce && !ser_ce) ce_falls++;
            if (!ser_ce) ce_low_run++;
            else begin
                if (!pce && ce_seen && ce_low_run < HALF) gap_err++;
                ce_low_run = 0;
                ce_seen = 1;
            end
            if (!ser_ce) nb = 0;
            pclk = ser_clk;
            pce  = ser_ce;
        end
    end

    // scoreboard monitor on completions
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (done_q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
            else begin
                if (done_q[0].rd) chk(rdata == done_q[0].v, "R6 read nibble", rdata, done_q[0].v);
                void'(done_q.pop_front());
            end
        end
    end

    task automatic access(input bit rd, input logic [3:0] a, input logic [3:0] d, input bit poke);
        bit seen;
        int guard;
        if (rd) begin
            byte_q.push_back(8'h60 | {4'h0, a});
            done_q.push_back('{1'b1, ref_mem[a]});
        end else begin
            byte_q.push_back(8'h20 | {4'h0, a});
            byte_q.push_back(8'h10 | {4'h0, d});
            ref_mem[a] = d;
            done_q.push_back('{1'b0, 4'h0});
        end
        @(negedge clk);
        req = 1'b1; rd_nwr = rd; addr = a; wdata = d;
        #1 chk(ack == 1'b1, "R2 ack when idle", ack, 1);
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R2 busy after ack", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            req = 1'b1; rd_nwr = 1'b0; addr = ~a;
            seen = 0;
            repeat (5) begin
                #1 if (ack) seen = 1;
                @(negedge clk);
            end
            req = 1'b0;
            chk(!seen, "R2 request while busy ignored", seen, 0);
        end
        guard = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk(busy == 1'b0, "R2 busy low after done", busy, 0);
        chk(done == 1'b0, "R10 done single cycle", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f0;
        for (int i = 0; i < 16; i++) begin
            ref_mem[i] = 4'(i * 3 + 1);
            dev_mem[i] = 4'(i * 3 + 1);
        end
        repeat (5) @(negedge clk);
        chk(ser_ce == 1'b0, "R1 ce in reset", ser_ce, 0);
        chk(ser_clk == 1'b1, "R1 clk in reset", ser_clk, 1);
        chk(sd_oe == 1'b0, "R1 oe in reset", sd_oe, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        access(0, 4'h3, 4'h9, 0);     // R7
        access(0, 4'hF, 4'h5, 0);     // R7
        access(1, 4'h3, 4'h0, 0);     // R5 R6
        access(1, 4'hF, 4'h0, 0);     // R5 R6
        access(1, 4'h7, 4'h0, 1);     // R2 ignored request, untouched register
        access(0, 4'h0, 4'hE, 0);
        access(1, 4'h0, 4'h0, 0);

        hold_en = 1'b1;
        repeat (3) @(negedge clk);
        f0 = ce_falls;
        chk(ser_ce == 1'b1, "R9 ce held while idle", ser_ce, 1);
        access(0, 4'h1, 4'hC, 0);
        access(1, 4'h1, 4'h0, 0);
        chk(ce_falls == f0, "R9 ce kept across accesses", ce_falls, f0);
        hold_en = 1'b0;
        repeat (2 * HALF) @(negedge clk);
        access(1, 4'h9, 4'h0, 0);

        repeat (4) @(negedge clk);
        chk(byte_q.size() == 0, "R5/R7 all bytes sent", byte_q.size(), 0);
        chk(done_q.size() == 0, "R10 all accesses completed", done_q.size(), 0);
        chk(oe_err == 0, "R4 output enable placement", oe_err, 0);
        chk(width_err == 0, "R3 low phase width", width_err, 0);
        chk(ce_err == 0, "R8 ce high during clocking", ce_err, 0);
        chk(gap_err == 0, "R9 ce recovery gap", gap_err, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule